// File: doc/BRIEF.md
# EX-Stage Operand Forwarding Unit

This block chooses, for each of the two ALU operands of a five-stage pipeline, where the operand value comes from. The instruction sitting in the execute stage names two source registers. If an older instruction that is still in flight will write one of those registers, the operand is taken from the pipeline instead of from the stale register-file read. There are two candidate sources. The first is the ALU result held after the execute stage. The second is the final value held after the memory stage, which is load data when that older instruction was a load.

The select logic is combinational. The top module also carries the two downstream pipeline registers, the operand multiplexers and an adder that stands in for the ALU, so that a result produced in one cycle is visibly forwarded in the following cycles. The caller presents the execute-stage instruction fields and register-file values every cycle. During the memory stage the caller also supplies the memory read data. Load-use stalling and register-file write-through are handled elsewhere.

Top module: `exfwd_top`

## Requirements
- R1: When the instruction one ahead (in the memory stage) writes a register, its destination is not 0, and that destination equals an operand's source register, that operand's select is 2'b10 and the operand equals that instruction's ALU result.
- R2: When the instruction two ahead (in write-back) writes a nonzero destination equal to an operand's source register, and R1 does not apply to that operand, the select is 2'b01 and the operand equals the write-back value.
- R3: When both older instructions write the same nonzero register that an operand reads, the nearer one wins: select 2'b10 with the memory-stage ALU result.
- R4: A destination of register 0 never forwards, even with its write enable set.
- R5: An older instruction whose write enable is clear never forwards, even when its destination matches.
- R6: Operand A (from `ex_ra`) and operand B (from `ex_rb`) are resolved independently with the same rules; select value 2'b11 never appears.
- R7: With no match, the select is 2'b00 and the operand equals the register-file value unchanged.
- R8: For a load, the write-back value is the `mem_rdata` presented in the cycle the load occupies the memory stage, not its ALU result.
- R9: After reset both downstream stages hold no writer, so the first instruction issued takes both operands from the register file.
- R10: `alu_y` is the sum of the two selected operands, and it is the value forwarded by R1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_ra | input | 5 | Execute-stage source register for operand A |
| ex_rb | input | 5 | Execute-stage source register for operand B |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| rf_a | input | 32 | Register-file value read for operand A |
| rf_b | input | 32 | Register-file value read for operand B |
| mem_rdata | input | 32 | Memory read data for the instruction in the memory stage |
| sel_a | output | 2 | Operand A source: 00 file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Operand B source, same encoding |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |
| alu_y | output | 32 | Sum of the selected operands |

## Verification
A corrupted destination or write-enable bit in either downstream stage shows up at once, in the same cycle, as a wrong select code and a wrong operand on `sel_a`/`sel_b` and `op_a`/`op_b`. It also shows up one cycle later, as a wrong `alu_y` that is then forwarded again. A wrong priority is exposed only when both stages target the same register, so the stimulus builds that collision on purpose. A wrong load value appears two cycles after the load issues, when a dependent instruction reads the write-back source.

// File: rtl/exfwd_pkg.sv
package exfwd_pkg;
   typedef enum logic [1:0] {
      SRC_RF    = 2'b00,
      SRC_MEMWB = 2'b01,
      SRC_EXMEM = 2'b10
   } src_sel_e;
endpackage

// File: rtl/exfwd_pick.sv
module exfwd_pick
   import exfwd_pkg::*;
#(
   parameter int AW       = 5,
   parameter bit EM_FWD_EN = 1'b1,
   parameter bit MW_FWD_EN = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] em_rd,
   input  logic          em_we,
   input  logic [AW-1:0] mw_rd,
   input  logic          mw_we,
   output src_sel_e      sel
);
   logic hit_em, hit_mw;

   generate
      if (EM_FWD_EN) begin : g_em
         assign hit_em = em_we && (em_rd != '0) && (em_rd == src);
      end else begin : g_no_em
         logic unused_em;
         assign unused_em = ^{em_rd, em_we};
         assign hit_em    = 1'b0;
      end
      if (MW_FWD_EN) begin : g_mw
         assign hit_mw = mw_we && (mw_rd != '0) && (mw_rd == src);
      end else begin : g_no_mw
         logic unused_mw;
         assign unused_mw = ^{mw_rd, mw_we};
         assign hit_mw    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (hit_em)      sel = SRC_EXMEM;
      else if (hit_mw) sel = SRC_MEMWB;
      else             sel = SRC_RF;
   end
endmodule

// File: rtl/exfwd_mux.sv
module exfwd_mux
   import exfwd_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  src_sel_e          sel,
   input  logic [XLEN-1:0]   rf_val,
   input  logic [XLEN-1:0]   em_val,
   input  logic [XLEN-1:0]   mw_val,
   output logic [XLEN-1:0]   val
);
   always_comb begin
      unique case (sel)
         SRC_EXMEM: val = em_val;
         SRC_MEMWB: val = mw_val;
         default:   val = rf_val;
      endcase
   end
endmodule

// File: rtl/exfwd_stage.sv
module exfwd_stage #(
   parameter int XLEN = 32,
   parameter int AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   in_rd,
   input  logic            in_we,
   input  logic [XLEN-1:0] in_val,
   output logic [AW-1:0]   out_rd,
   output logic            out_we,
   output logic [XLEN-1:0] out_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_rd  <= '0;
         out_we  <= 1'b0;
         out_val <= '0;
      end else begin
         out_rd  <= in_rd;
         out_we  <= in_we;
         out_val <= in_val;
      end
   end
endmodule

// File: rtl/exfwd_top.sv
module exfwd_top
   import exfwd_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter bit EM_FWD_EN = 1'b1,
   parameter bit MW_FWD_EN = 1'b1,
   localparam int AW       = $clog2(NREG),
   localparam int NOPND    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ex_ra,
   input  logic [AW-1:0]   ex_rb,
   input  logic [AW-1:0]   ex_rd,
   input  logic            ex_we,
   input  logic            ex_load,
   input  logic [XLEN-1:0] rf_a,
   input  logic [XLEN-1:0] rf_b,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [1:0]      sel_a,
   output logic [1:0]      sel_b,
   output logic [XLEN-1:0] op_a,
   output logic [XLEN-1:0] op_b,
   output logic [XLEN-1:0] alu_y
);
   initial begin
      assert (NREG >= 2 && (1 << AW) == NREG)
         else $error("NREG must be a power of two, at least 2");
      assert (XLEN >= 1)
         else $error("XLEN must be positive");
   end

   logic [AW-1:0]   em_rd, mw_rd;
   logic            em_we, mw_we, em_load;
   logic [XLEN-1:0] em_alu, mw_val, wb_val;

   logic [AW-1:0]   src   [NOPND];
   logic [XLEN-1:0] rfv   [NOPND];
   logic [XLEN-1:0] opv   [NOPND];
   src_sel_e        selv  [NOPND];

   assign src[0] = ex_ra;
   assign src[1] = ex_rb;
   assign rfv[0] = rf_a;
   assign rfv[1] = rf_b;

   generate
      for (genvar g = 0; g < NOPND; g++) begin : g_opnd
         exfwd_pick #(.AW(AW), .EM_FWD_EN(EM_FWD_EN), .MW_FWD_EN(MW_FWD_EN)) i_pick (
            .src   (src[g]),
            .em_rd (em_rd),
            .em_we (em_we),
            .mw_rd (mw_rd),
            .mw_we (mw_we),
            .sel   (selv[g])
         );
         exfwd_mux #(.XLEN(XLEN)) i_mux (
            .sel    (selv[g]),
            .rf_val (rfv[g]),
            .em_val (em_alu),
            .mw_val (mw_val),
            .val    (opv[g])
         );
      end
   endgenerate

   assign sel_a = selv[0];
   assign sel_b = selv[1];
   assign op_a  = opv[0];
   assign op_b  = opv[1];
   assign alu_y = opv[0] + opv[1];

   // memory stage: loads replace the ALU result with read data
   assign wb_val = em_load ? mem_rdata : em_alu;

   exfwd_stage #(.XLEN(XLEN), .AW(AW)) i_exmem (
      .clk(clk), .rst_n(rst_n),
      .in_rd(ex_rd), .in_we(ex_we), .in_val(alu_y),
      .out_rd(em_rd), .out_we(em_we), .out_val(em_alu)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) em_load <= 1'b0;
      else        em_load <= ex_load;
   end

   exfwd_stage #(.XLEN(XLEN), .AW(AW)) i_memwb (
      .clk(clk), .rst_n(rst_n),
      .in_rd(em_rd), .in_we(em_we), .in_val(wb_val),
      .out_rd(mw_rd), .out_we(mw_we), .out_val(mw_val)
   );
endmodule

// File: rtl/exfwd_chk.sv
module exfwd_chk #(
   parameter int XLEN = 32,
   parameter int AW   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   ex_ra,
   input logic [AW-1:0]   ex_rb,
   input logic [AW-1:0]   em_rd,
   input logic            em_we,
   input logic [XLEN-1:0] em_alu,
   input logic [AW-1:0]   mw_rd,
   input logic            mw_we,
   input logic [XLEN-1:0] mw_val,
   input logic [1:0]      sel_a,
   input logic [1:0]      sel_b,
   input logic [XLEN-1:0] op_a,
   input logic [XLEN-1:0] op_b,
   input logic [XLEN-1:0] alu_y
);
   // R1
   em_data_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_a == 2'b10 |-> op_a == em_alu);
   // R2
   mw_data_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_b == 2'b01 |-> op_b == mw_val);
   // R3
   near_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (em_we && mw_we && em_rd != '0 && em_rd == mw_rd && ex_ra == em_rd) |-> sel_a == 2'b10);
   // R4
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_ra == '0) |-> sel_a == 2'b00);
   // R5
   no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!em_we && !mw_we) |-> (sel_a == 2'b00 && sel_b == 2'b00));
   // R6
   legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_a != 2'b11 && sel_b != 2'b11);
   // R10
   alu_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> em_alu == $past(alu_y));
endmodule

bind exfwd_top exfwd_chk #(.XLEN(XLEN), .AW(AW)) i_exfwd_chk (
   .clk(clk), .rst_n(rst_n), .ex_ra(ex_ra), .ex_rb(ex_rb),
   .em_rd(em_rd), .em_we(em_we), .em_alu(em_alu),
   .mw_rd(mw_rd), .mw_we(mw_we), .mw_val(mw_val),
   .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b), .alu_y(alu_y)
);

// File: tb/test_exfwd_top.sv
module test_exfwd_top;
   localparam int PERIOD = 10;

   typedef struct {
      logic [1:0]  sa, sb;
      logic [31:0] oa, ob, y;
      string       tag;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [4:0]  ex_ra = '0, ex_rb = '0, ex_rd = '0;
   logic        ex_we = 1'b0, ex_load = 1'b0;
   logic [31:0] rf_a = '0, rf_b = '0, mem_rdata = '0;
   logic [1:0]  sel_a, sel_b;
   logic [31:0] op_a, op_b, alu_y;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   exp_t q[$];

   // bench model of the two downstream stages
   logic [4:0]  m_em_rd = '0, m_mw_rd = '0;
   logic        m_em_we = 1'b0, m_mw_we = 1'b0, m_em_ld = 1'b0;
   logic [31:0] m_em_val = '0, m_mw_val = '0;

   always #(PERIOD/2) clk = ~clk;

   exfwd_top i_exfwd_top (
      .clk(clk), .rst_n(rst_n), .ex_ra(ex_ra), .ex_rb(ex_rb), .ex_rd(ex_rd),
      .ex_we(ex_we), .ex_load(ex_load), .rf_a(rf_a), .rf_b(rf_b),
      .mem_rdata(mem_rdata), .sel_a(sel_a), .sel_b(sel_b),
      .op_a(op_a), .op_b(op_b), .alu_y(alu_y)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] ra, rb, rd, input logic we, ld,
                        input logic [31:0] fa, fb, mrd, input string tag);
      exp_t e;
      logic [31:0] wbv;
      @(negedge clk);
      ex_ra = ra; ex_rb = rb; ex_rd = rd; ex_we = we; ex_load = ld;
      rf_a = fa; rf_b = fb; mem_rdata = mrd;
      wbv = m_em_ld ? mrd : m_em_val;
      if (m_em_we && m_em_rd != 0 && m_em_rd == ra)      begin e.sa = 2'b10; e.oa = m_em_val; end
      else if (m_mw_we && m_mw_rd != 0 && m_mw_rd == ra) begin e.sa = 2'b01; e.oa = m_mw_val; end
      else                                               begin e.sa = 2'b00; e.oa = fa; end
      if (m_em_we && m_em_rd != 0 && m_em_rd == rb)      begin e.sb = 2'b10; e.ob = m_em_val; end
      else if (m_mw_we && m_mw_rd != 0 && m_mw_rd == rb) begin e.sb = 2'b01; e.ob = m_mw_val; end
      else                                               begin e.sb = 2'b00; e.ob = fb; end
      e.y = e.oa + e.ob;
      e.tag = tag;
      q.push_back(e);
      m_mw_rd = m_em_rd; m_mw_we = m_em_we; m_mw_val = wbv;
      m_em_rd = rd; m_em_we = we; m_em_ld = ld; m_em_val = e.y;
   endtask

   // monitor: compare a quarter period after each drive
   initial begin
      forever begin
         @(negedge clk);
         #(PERIOD/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(sel_a == e.sa, e.tag, "sel_a", 32'(sel_a), 32'(e.sa));
            check(sel_b == e.sb, e.tag, "sel_b", 32'(sel_b), 32'(e.sb));
            check(op_a  == e.oa, e.tag, "op_a", op_a, e.oa);
            check(op_b  == e.ob, e.tag, "op_b", op_b, e.ob);
            check(alu_y == e.y,  e.tag, "alu_y R10", alu_y, e.y);
         end
      end
   end

   initial begin
      #(PERIOD*5000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: first instruction after reset reads the file
      issue(5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 32'd10, 32'd20, 32'd0, "R9");
      // R1: operand A from the nearer stage; R7 on B
      issue(5'd3, 5'd7, 5'd4, 1'b1, 1'b0, 32'd1, 32'd5, 32'd0, "R1 R7");
      // R2 on A, R1 on B, R6 independence
      issue(5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 32'd2, 32'd3, 32'd0, "R2 R6");
      // R3: both stages write r9, nearer wins
      issue(5'd1, 5'd2, 5'd9, 1'b1, 1'b0, 32'd100, 32'd1, 32'd0, "R3 setup");
      issue(5'd1, 5'd2, 5'd9, 1'b1, 1'b0, 32'd200, 32'd2, 32'd0, "R3 setup");
      issue(5'd9, 5'd9, 5'd0, 1'b0, 1'b0, 32'd7, 32'd8, 32'd0, "R3");
      // R4: writes to r0 never forward
      issue(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 32'd11, 32'd12, 32'd0, "R4 setup");
      issue(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 32'd13, 32'd14, 32'd0, "R4");
      issue(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 32'd15, 32'd16, 32'd0, "R4");
      // R5: matching destination with write enable clear
      issue(5'd1, 5'd2, 5'd6, 1'b0, 1'b0, 32'd21, 32'd22, 32'd0, "R5 setup");
      issue(5'd6, 5'd6, 5'd6, 1'b0, 1'b0, 32'd23, 32'd24, 32'd0, "R5");
      issue(5'd6, 5'd1, 5'd0, 1'b0, 1'b0, 32'd25, 32'd26, 32'd0, "R5");
      // R8: load r7, read data arrives while it is in the memory stage
      issue(5'd1, 5'd2, 5'd7, 1'b1, 1'b1, 32'd1, 32'd1, 32'd0, "R8 setup");
      issue(5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 32'd30, 32'd31, 32'h77, "R8 setup");
      issue(5'd7, 5'd7, 5'd0, 1'b0, 1'b0, 32'd40, 32'd41, 32'h99, "R8");
      // mixed patterns on a few registers to force collisions (R6)
      lf = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue({3'b0, lf[1:0]}, {3'b0, lf[3:2]}, {3'b0, lf[5:4]}, lf[6], lf[7],
               {16'h0, lf}, {lf, 16'h0}, {lf[7:0], lf, lf[15:8]}, "R6");
      end
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule